// File: doc/BRIEF.md
# Banked Data Register File with Context Save

This block is the working register file of a processing element. It keeps sixteen architectural data registers. Each one has two physical copies, a primary and a shadow. One bit of a mode register chooses which copy the read and write ports reach. Changing that bit gives interrupt code a complete set of private registers, with no save or restore through memory.

Alongside the file the block holds two arithmetic status words, one for each processing element, and the mode word. When an enabled interrupt is taken, an entry strobe copies all three words onto a small hardware stack in a single cycle. A return strobe pops them back. Because the bank bit is part of the mode word, a return also restores the bank that was active before the interrupt.

The read ports are combinational. The write ports, the status and mode update ports and the stack act on the rising clock edge. Interrupt prioritisation and the arithmetic units are outside this block.

Top module: `bank_regfile`

## Requirements
- R1: After reset, every register in both banks reads zero. Both status words and the mode word are zero, so the primary bank is selected. The stack is empty and both stack flags are low.
- R2: Each of the NRD read ports returns, combinationally, the register its address names in the current bank. A read of a register that is being written in the same cycle returns the old value. The new value appears after the clock edge.
- R3: When two or more enabled write ports target the same register in one cycle, the highest-numbered port's data is stored. Enabled ports that target different registers all store in the same cycle.
- R4: Bit BANK_BIT of the mode word (bit 0 by default) selects the bank: 0 selects primary and 1 selects shadow. The bit applies to both reads and writes. Writes to one bank leave the other bank unchanged. A mode write changes the bank only from the following cycle, so a data write in the same cycle as the mode write goes to the old bank.
- R5: stat_we loads both status inputs, and mode_we loads the mode input, at the next clock edge. The stored values appear on stat_x, stat_y and mode.
- R6: irq_enter pushes the current {stat_x, stat_y, mode} onto the stack. The values captured are those from before any same-cycle update. The push does not by itself change the visible status or mode.
- R7: irq_return pops the most recent entry and restores stat_x, stat_y and mode from it, which also restores the bank selection. Entries come back in last-in, first-out order.
- R8: irq_enter while the stack already holds STK_DEPTH entries sets stk_ovf high for exactly one cycle and discards the push. The stored entries are unchanged.
- R9: irq_return while the stack is empty sets stk_unf high for exactly one cycle and leaves status and mode unchanged.
- R10: When irq_return is asserted in the same cycle as irq_enter, stat_we or mode_we, only the pop takes effect. The push is dropped and the restored values override the writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr | input | NRD x log2(NREG) | Register number for each read port |
| rd_data | output | NRD x DATA_W | Combinational read data for each port |
| wr_en | input | NWR | Write enable for each write port |
| wr_addr | input | NWR x log2(NREG) | Register number for each write port |
| wr_data | input | NWR x DATA_W | Write data for each write port |
| stat_we | input | 1 | Load both status words |
| stat_x_in | input | STAT_W | New status for the first processing element |
| stat_y_in | input | STAT_W | New status for the second processing element |
| mode_we | input | 1 | Load the mode word |
| mode_in | input | MODE_W | New mode word |
| irq_enter | input | 1 | Interrupt entry strobe (push) |
| irq_return | input | 1 | Interrupt return strobe (pop) |
| stat_x | output | STAT_W | Current status, first processing element |
| stat_y | output | STAT_W | Current status, second processing element |
| mode | output | MODE_W | Current mode word |
| stk_ovf | output | 1 | One-cycle pulse on a push to a full stack |
| stk_unf | output | 1 | One-cycle pulse on a pop from an empty stack |

## Verification
The bench builds the block with 16-bit data and 4-bit status and mode words, and keeps the default port counts and stack depth of four. At these widths every one of the 32 physical registers is written and then read back through all six read ports in both banks. Every one of the 15 non-empty write-enable combinations is driven onto a single register. The stack can be filled past its depth and drained past empty within a few dozen cycles, so overflow, underflow and last-in, first-out order are checked at both ends.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;

    localparam int unsigned DEF_DATA_W    = 40;
    localparam int unsigned DEF_NREG      = 16;
    localparam int unsigned DEF_NRD       = 6;
    localparam int unsigned DEF_NWR       = 4;
    localparam int unsigned DEF_STAT_W    = 8;
    localparam int unsigned DEF_MODE_W    = 8;
    localparam int unsigned DEF_STK_DEPTH = 4;
    localparam int unsigned DEF_BANK_BIT  = 0;

    typedef enum logic [1:0] {
        CTX_HOLD = 2'd0,
        CTX_PUSH = 2'd1,
        CTX_POP  = 2'd2
    } ctx_op_e;

    // A return always takes precedence over a simultaneous entry.
    function automatic ctx_op_e ctx_decode(input logic enter, input logic ret);
        if (ret)        return CTX_POP;
        else if (enter) return CTX_PUSH;
        else            return CTX_HOLD;
    endfunction

endpackage

// File: rtl/rf_bank_store.sv
module rf_bank_store #(
    parameter int unsigned DATA_W = 40,
    parameter int unsigned NREG   = 16,
    parameter int unsigned NRD    = 6,
    parameter int unsigned NWR    = 4,
    localparam int unsigned AW    = $clog2(NREG),
    localparam int unsigned PHYS  = 2 * NREG
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bank_sel,
    input  logic [NRD-1:0][AW-1:0]       rd_addr,
    output logic [NRD-1:0][DATA_W-1:0]   rd_data,
    input  logic [NWR-1:0]               wr_en,
    input  logic [NWR-1:0][AW-1:0]       wr_addr,
    input  logic [NWR-1:0][DATA_W-1:0]   wr_data
);

    typedef struct packed {
        logic [PHYS-1:0][DATA_W-1:0] regs;
    } store_t;

    store_t store_d, store_q;

    // Later ports overwrite earlier ones, so the highest-numbered port wins.
    always_comb begin
        store_d = store_q;
        for (int w = 0; w < NWR; w++) begin
            if (wr_en[w]) begin
                store_d.regs[{bank_sel, wr_addr[w]}] = wr_data[w];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) store_q <= '0;
        else        store_q <= store_d;
    end

    // Reads see registered state only: old value during a write.
    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_data[r] = store_q.regs[{bank_sel, rd_addr[r]}];
    end

endmodule

// File: rtl/rf_ctx_stack.sv
module rf_ctx_stack
    import bank_rf_pkg::*;
#(
    parameter int unsigned STAT_W = 8,
    parameter int unsigned MODE_W = 8,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned CW    = $clog2(DEPTH + 1),
    localparam int unsigned ENT_W = 2 * STAT_W + MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_we,
    input  logic [STAT_W-1:0] stat_x_in,
    input  logic [STAT_W-1:0] stat_y_in,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              irq_enter,
    input  logic              irq_return,
    output logic [STAT_W-1:0] stat_x,
    output logic [STAT_W-1:0] stat_y,
    output logic [MODE_W-1:0] mode,
    output logic              stk_ovf,
    output logic              stk_unf
);

    typedef struct packed {
        logic [DEPTH-1:0][ENT_W-1:0] stk;
        logic [CW-1:0]               cnt;
        logic [STAT_W-1:0]           sx;
        logic [STAT_W-1:0]           sy;
        logic [MODE_W-1:0]           md;
        logic                        ovf;
        logic                        unf;
    } ctx_t;

    ctx_t          ctx_d, ctx_q;
    ctx_op_e       op;
    logic [ENT_W-1:0] top_ent;
    logic          full, empty;

    assign op    = ctx_decode(irq_enter, irq_return);
    assign full  = (ctx_q.cnt == CW'(DEPTH));
    assign empty = (ctx_q.cnt == '0);

    always_comb begin
        top_ent = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) == ctx_q.cnt - CW'(1)) top_ent = ctx_q.stk[i];
        end
    end

    always_comb begin
        ctx_d     = ctx_q;
        ctx_d.ovf = 1'b0;
        ctx_d.unf = 1'b0;
        if (stat_we) begin
            ctx_d.sx = stat_x_in;
            ctx_d.sy = stat_y_in;
        end
        if (mode_we) ctx_d.md = mode_in;
        unique case (op)
            CTX_PUSH: begin
                if (full) begin
                    ctx_d.ovf = 1'b1;
                end else begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if (CW'(i) == ctx_q.cnt) ctx_d.stk[i] = {ctx_q.sx, ctx_q.sy, ctx_q.md};
                    end
                    ctx_d.cnt = ctx_q.cnt + CW'(1);
                end
            end
            CTX_POP: begin
                if (empty) begin
                    ctx_d.unf = 1'b1;
                    ctx_d.sx  = ctx_q.sx;
                    ctx_d.sy  = ctx_q.sy;
                    ctx_d.md  = ctx_q.md;
                end else begin
                    ctx_d.sx  = top_ent[ENT_W-1 -: STAT_W];
                    ctx_d.sy  = top_ent[MODE_W +: STAT_W];
                    ctx_d.md  = top_ent[MODE_W-1:0];
                    ctx_d.cnt = ctx_q.cnt - CW'(1);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign stat_x  = ctx_q.sx;
    assign stat_y  = ctx_q.sy;
    assign mode    = ctx_q.md;
    assign stk_ovf = ctx_q.ovf;
    assign stk_unf = ctx_q.unf;

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
    import bank_rf_pkg::*;
#(
    parameter int unsigned DATA_W    = DEF_DATA_W,
    parameter int unsigned NREG      = DEF_NREG,
    parameter int unsigned NRD       = DEF_NRD,
    parameter int unsigned NWR       = DEF_NWR,
    parameter int unsigned STAT_W    = DEF_STAT_W,
    parameter int unsigned MODE_W    = DEF_MODE_W,
    parameter int unsigned STK_DEPTH = DEF_STK_DEPTH,
    parameter int unsigned BANK_BIT  = DEF_BANK_BIT,
    localparam int unsigned AW       = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NRD-1:0][AW-1:0]     rd_addr,
    output logic [NRD-1:0][DATA_W-1:0] rd_data,
    input  logic [NWR-1:0]             wr_en,
    input  logic [NWR-1:0][AW-1:0]     wr_addr,
    input  logic [NWR-1:0][DATA_W-1:0] wr_data,
    input  logic                       stat_we,
    input  logic [STAT_W-1:0]          stat_x_in,
    input  logic [STAT_W-1:0]          stat_y_in,
    input  logic                       mode_we,
    input  logic [MODE_W-1:0]          mode_in,
    input  logic                       irq_enter,
    input  logic                       irq_return,
    output logic [STAT_W-1:0]          stat_x,
    output logic [STAT_W-1:0]          stat_y,
    output logic [MODE_W-1:0]          mode,
    output logic                       stk_ovf,
    output logic                       stk_unf
);

    logic bank_sel;

    rf_ctx_stack #(
        .STAT_W (STAT_W),
        .MODE_W (MODE_W),
        .DEPTH  (STK_DEPTH)
    ) i_ctx (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_we    (stat_we),
        .stat_x_in  (stat_x_in),
        .stat_y_in  (stat_y_in),
        .mode_we    (mode_we),
        .mode_in    (mode_in),
        .irq_enter  (irq_enter),
        .irq_return (irq_return),
        .stat_x     (stat_x),
        .stat_y     (stat_y),
        .mode       (mode),
        .stk_ovf    (stk_ovf),
        .stk_unf    (stk_unf)
    );

    // Registered mode bit: a mode write moves the bank from the next cycle.
    assign bank_sel = mode[BANK_BIT];

    rf_bank_store #(
        .DATA_W (DATA_W),
        .NREG   (NREG),
        .NRD    (NRD),
        .NWR    (NWR)
    ) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank_sel (bank_sel),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

endmodule

// File: rtl/rf_ctx_checker.sv
module rf_ctx_checker #(
    parameter int unsigned DATA_W = 40,
    parameter int unsigned NREG   = 16,
    parameter int unsigned NRD    = 6,
    parameter int unsigned NWR    = 4,
    parameter int unsigned STAT_W = 8,
    parameter int unsigned MODE_W = 8,
    localparam int unsigned AW    = $clog2(NREG)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NRD-1:0][AW-1:0]     rd_addr,
    input logic [NRD-1:0][DATA_W-1:0] rd_data,
    input logic [NWR-1:0]             wr_en,
    input logic                       stat_we,
    input logic                       mode_we,
    input logic                       irq_enter,
    input logic                       irq_return,
    input logic [STAT_W-1:0]          stat_x,
    input logic [STAT_W-1:0]          stat_y,
    input logic [MODE_W-1:0]          mode,
    input logic                       stk_ovf,
    input logic                       stk_unf
);

    AST_OVF_FROM_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_enter || irq_return) |=> !stk_ovf) else $error("overflow without push"); // R8

    AST_UNF_FROM_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_return |=> !stk_unf) else $error("underflow without pop"); // R9

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_ovf && stk_unf)) else $error("both stack flags"); // R10

    AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_we && !irq_return) |=> $stable(mode)) else $error("mode moved"); // R6

    AST_STAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_we && !irq_return) |=> ($stable(stat_x) && $stable(stat_y))) else $error("status moved"); // R5

    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == '0 && !mode_we && !irq_return) |=> ($stable(rd_addr) -> $stable(rd_data)))
        else $error("read data moved without write"); // R2

endmodule

bind bank_regfile rf_ctx_checker #(
    .DATA_W (DATA_W),
    .NREG   (NREG),
    .NRD    (NRD),
    .NWR    (NWR),
    .STAT_W (STAT_W),
    .MODE_W (MODE_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .wr_en      (wr_en),
    .stat_we    (stat_we),
    .mode_we    (mode_we),
    .irq_enter  (irq_enter),
    .irq_return (irq_return),
    .stat_x     (stat_x),
    .stat_y     (stat_y),
    .mode       (mode),
    .stk_ovf    (stk_ovf),
    .stk_unf    (stk_unf)
);

// File: tb/test_bank_regfile.sv
`timescale 1ns/1ps
module test_bank_regfile;

    localparam int DW = 16, NREG = 16, NRD = 6, NWR = 4, SW = 4, MW = 4, DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NRD-1:0][3:0]    rd_addr = '0;
    logic [NRD-1:0][DW-1:0] rd_data;
    logic [NWR-1:0]         wr_en = '0;
    logic [NWR-1:0][3:0]    wr_addr = '0;
    logic [NWR-1:0][DW-1:0] wr_data = '0;
    logic          stat_we = 1'b0, mode_we = 1'b0, irq_enter = 1'b0, irq_return = 1'b0;
    logic [SW-1:0] stat_x_in = '0, stat_y_in = '0;
    logic [MW-1:0] mode_in = '0;
    logic [SW-1:0] stat_x, stat_y;
    logic [MW-1:0] mode;
    logic          stk_ovf, stk_unf;

    logic [DW-1:0] mdl [2][NREG];
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    bank_regfile #(
        .DATA_W(DW), .NREG(NREG), .NRD(NRD), .NWR(NWR),
        .STAT_W(SW), .MODE_W(MW), .STK_DEPTH(DEPTH), .BANK_BIT(0)
    ) i_bank_regfile (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .stat_we(stat_we), .stat_x_in(stat_x_in), .stat_y_in(stat_y_in),
        .mode_we(mode_we), .mode_in(mode_in), .irq_enter(irq_enter), .irq_return(irq_return),
        .stat_x(stat_x), .stat_y(stat_y), .mode(mode), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_mode(input logic [MW-1:0] m);
        mode_in = m; mode_we = 1'b1;
        step();
        mode_we = 1'b0;
    endtask

    task automatic check_ctx(input string req, input int sx, input int sy, input int md, input int ov, input int un);
        check(req, {28'd0, stat_x}, sx);
        check(req, {28'd0, stat_y}, sy);
        check(req, {28'd0, mode}, md);
        check(req, {31'd0, stk_ovf}, ov);
        check(req, {31'd0, stk_unf}, un);
    endtask

    // Reads every register of bank b through all six ports (bank already selected).
    task automatic sweep_bank(input string req, input int b);
        for (int a = 0; a < NREG; a++) begin
            for (int r = 0; r < NRD; r++) rd_addr[r] = 4'((a + r) % NREG);
            #1;
            for (int r = 0; r < NRD; r++) check(req, {16'd0, rd_data[r]}, {16'd0, mdl[b][(a + r) % NREG]});
        end
    endtask

    task automatic set_stat(input int sx, input int sy);
        stat_x_in = SW'(sx); stat_y_in = SW'(sy); stat_we = 1'b1;
        step();
        stat_we = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        for (int b = 0; b < 2; b++) for (int a = 0; a < NREG; a++) mdl[b][a] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;

        // R1: reset state
        sweep_bank("R1", 0);
        check_ctx("R1", 0, 0, 0, 0, 0);

        // R2, R4: fill both banks, check old-value read during write
        for (int b = 0; b < 2; b++) begin
            set_mode(MW'(b));
            for (int a = 0; a < NREG; a++) begin
                int w = a % NWR;
                logic [DW-1:0] v = DW'(16'h1000 * (b + 1) + a * 16'h0101 + 16'h0011 * w);
                wr_en = '0; wr_en[w] = 1'b1; wr_addr[w] = 4'(a); wr_data[w] = v;
                rd_addr[0] = 4'(a);
                #1 check("R2 old", {16'd0, rd_data[0]}, {16'd0, mdl[b][a]});
                step();
                wr_en = '0;
                mdl[b][a] = v;
                check("R2 new", {16'd0, rd_data[0]}, {16'd0, v});
            end
        end
        set_mode(4'd0);
        sweep_bank("R4 primary", 0);
        set_mode(4'd1);
        sweep_bank("R4 shadow", 1);

        // R3: every enable combination on one register
        for (int m = 1; m < 16; m++) begin
            int hi = 0;
            for (int w = 0; w < NWR; w++) begin
                wr_addr[w] = 4'd5;
                wr_data[w] = DW'(16'h5000 + m * 16 + w);
                if (m[w]) hi = w;
            end
            wr_en = NWR'(m);
            step();
            wr_en = '0;
            mdl[1][5] = DW'(16'h5000 + m * 16 + hi);
            rd_addr[0] = 4'd5;
            #1 check("R3 priority", {16'd0, rd_data[0]}, {16'd0, mdl[1][5]});
        end
        for (int w = 0; w < NWR; w++) begin
            wr_addr[w] = 4'(8 + w); wr_data[w] = DW'(16'hC000 + w);
            mdl[1][8 + w] = DW'(16'hC000 + w);
        end
        wr_en = '1;
        step();
        wr_en = '0;
        sweep_bank("R3 distinct", 1);

        // R4: write in the same cycle as a bank switch goes to the old bank
        mode_in = 4'd0; mode_we = 1'b1;
        wr_en = 4'b0001; wr_addr[0] = 4'd3; wr_data[0] = 16'hBEEF;
        step();
        mode_we = 1'b0; wr_en = '0;
        mdl[1][3] = 16'hBEEF;
        sweep_bank("R4 switch primary", 0);
        set_mode(4'd1);
        sweep_bank("R4 switch shadow", 1);

        // R5: status and mode load
        set_stat(4'h9, 4'h6);
        set_mode(4'hA);
        check_ctx("R5", 4'h9, 4'h6, 4'hA, 0, 0);

        // R6, R7: nested entry and return
        set_stat(1, 2); set_mode(4'h1);
        irq_enter = 1'b1; step(); irq_enter = 1'b0;
        check_ctx("R6 push holds", 1, 2, 1, 0, 0);
        set_stat(3, 4); set_mode(4'h0);
        irq_enter = 1'b1; stat_x_in = 4'hE; stat_y_in = 4'hE; stat_we = 1'b1;
        step();
        irq_enter = 1'b0; stat_we = 1'b0;
        check_ctx("R6 same-cycle write", 4'hE, 4'hE, 0, 0, 0);
        set_mode(4'h2);
        irq_return = 1'b1; step(); irq_return = 1'b0;
        check_ctx("R7 pop1", 3, 4, 0, 0, 0);
        sweep_bank("R7 bank primary", 0);
        irq_return = 1'b1; step(); irq_return = 1'b0;
        check_ctx("R7 pop2", 1, 2, 1, 0, 0);
        sweep_bank("R7 bank shadow", 1);

        // R8: overflow
        for (int i = 0; i < DEPTH + 1; i++) begin
            set_stat(i + 1, 8 + i); set_mode(MW'(i + 2));
            irq_enter = 1'b1; step(); irq_enter = 1'b0;
            check("R8 flag", {31'd0, stk_ovf}, (i == DEPTH) ? 1 : 0);
        end
        step();
        check("R8 pulse", {31'd0, stk_ovf}, 0);
        // R7, R8: last-in first-out, discarded fifth entry
        for (int i = DEPTH - 1; i >= 0; i--) begin
            irq_return = 1'b1; step(); irq_return = 1'b0;
            check_ctx("R7 lifo", i + 1, 8 + i, i + 2, 0, 0);
        end
        // R9: underflow
        irq_return = 1'b1; step(); irq_return = 1'b0;
        check_ctx("R9 flag", 1, 8, 2, 0, 1);
        step();
        check("R9 pulse", {31'd0, stk_unf}, 0);

        // R10: return beats entry and writes
        set_stat(5, 6); set_mode(4'h1);
        irq_enter = 1'b1; step(); irq_enter = 1'b0;
        set_stat(7, 7);
        irq_return = 1'b1; irq_enter = 1'b1; stat_we = 1'b1; mode_we = 1'b1;
        stat_x_in = 4'hF; stat_y_in = 4'hF; mode_in = 4'h0;
        step();
        irq_return = 1'b0; irq_enter = 1'b0; stat_we = 1'b0; mode_we = 1'b0;
        check_ctx("R10 pop wins", 5, 6, 1, 0, 0);
        irq_return = 1'b1; step(); irq_return = 1'b0;
        check_ctx("R10 push dropped", 5, 6, 1, 0, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule